// File: doc/BRIEF.md
# Double-Buffered Converter Code Register Pair

This block is the digital front end of an 8-bit voltage-output converter. It keeps two code stages in a chain. A front stage takes its value from the data bus. A back stage takes its value from the front stage. Only the back stage drives the code that sets the resistor ladder. Because of the two stages, a system with many converters can load each front stage in turn and then move all of them to their outputs together.

Four active-low control lines set the behaviour: select, write strobe, transfer and clear. Each line acts on its level. The latch behaviour is modelled on the system clock. A stage that is open takes a new value on every clock edge. A stage that is closed keeps its value. When both stages are open, the bus flows through to the output in one clock. The clear line has priority over every other control. When both stages are open, clear forces the output to zero only while clear is held low. When both stages are closed, clear leaves zeros in both stages.

In unipolar use, the analog output is code/256 of the reference, so full scale is 255/256 of the reference. In offset-binary use, code 0x80 gives zero output and each step is 1/128 of the reference.

Top module: `dac_latch_pair`

## Requirements
- R1: While `rst` is high at a clock edge, both stages become 0. `out_code` reads 0x00 from the following cycle.
- R2: At an edge where `clr_n`=1, `sel_n`=0 and `wr_n`=0, the front stage loads `bus_data`.
- R3: At an edge where `clr_n`=1, `xfer_n`=0 and `wr_n`=0, the back stage loads the front stage's new value. If the front stage is also open, the new value is the current `bus_data`, so `out_code` equals that bus value one cycle later.
- R4: At an edge where `clr_n`=1 and `wr_n`=1, both stages keep their values, whatever `sel_n`, `xfer_n` and `bus_data` are.
- R5: At an edge where `clr_n`=1, `xfer_n`=1 and `sel_n`=1, both stages keep their values.
- R6: With `clr_n`=1, `xfer_n`=1, `sel_n`=0 and `wr_n`=0, only the front stage follows the bus and `out_code` is unchanged. The captured value reaches `out_code` only after a later cycle in which `xfer_n` and `wr_n` are both low.
- R7: At an edge where `clr_n`=0, both stages become 0, whatever the other controls are.
- R8: Zero override. With `sel_n`, `wr_n` and `xfer_n` all low, `out_code` is 0 for as long as `clr_n` stays low. On the cycle after `clr_n` returns high, `out_code` follows `bus_data` again.
- R9: A low pulse on `clr_n` while `wr_n`=1 leaves `out_code` at 0 after `clr_n` returns high, until new data is written and transferred.
- R10: After `wr_n` rises, the stages keep the bus value from the last cycle in which the strobe was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Code presented on the data bus |
| sel_n | input | 1 | Active-low select, opens the front stage together with `wr_n` |
| wr_n | input | 1 | Active-low write strobe, shared by both stages |
| xfer_n | input | 1 | Active-low transfer, opens the back stage together with `wr_n` |
| clr_n | input | 1 | Active-low clear / zero override, highest priority |
| out_code | output | 8 | Back-stage code that drives the ladder |

## Verification
Clear and a transfer can land in the same cycle. So can a front-stage load and a back-stage transfer. The bench sweeps all sixteen control combinations, each from a non-zero preloaded state and with bus values that differ from the stored codes. This exposes the first collision: clear must win over every open stage. It also exposes the second: with both stages open, the back stage must take the bus value of that same cycle and not the front stage's old content. A reference model built from the requirements judges each step, and directed sequences cover the clear-pulse and delayed-transfer corner cases.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;

    parameter int CODE_W = 8;
    localparam int BIPOLAR_MID = 1 << (CODE_W - 1);

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic sel_n;
        logic wr_n;
        logic xfer_n;
        logic clr_n;
    } ctrl_t;

    typedef enum logic [2:0] {
        MODE_HOLD  = 3'd0,
        MODE_FRONT = 3'd1,
        MODE_BACK  = 3'd2,
        MODE_FLOW  = 3'd3,
        MODE_CLEAR = 3'd4
    } mode_e;

    typedef struct packed {
        logic front_open;
        logic back_open;
        logic wipe;
    } stage_en_t;

    function automatic mode_e classify(input ctrl_t c);
        logic f;
        logic b;
        if (!c.clr_n) return MODE_CLEAR;
        f = !c.sel_n && !c.wr_n;
        b = !c.xfer_n && !c.wr_n;
        if (f && b) return MODE_FLOW;
        if (f) return MODE_FRONT;
        if (b) return MODE_BACK;
        return MODE_HOLD;
    endfunction

endpackage

// File: rtl/dac_ctrl_decode.sv
module dac_ctrl_decode
    import dac_latch_pkg::*;
(
    input  ctrl_t     ctrl,
    output stage_en_t en
);
    mode_e mode;

    always_comb begin
        mode = classify(ctrl);
        en   = '0;
        unique case (mode)
            MODE_CLEAR: en.wipe = 1'b1;
            MODE_FRONT: en.front_open = 1'b1;
            MODE_BACK:  en.back_open = 1'b1;
            MODE_FLOW: begin
                en.front_open = 1'b1;
                en.back_open  = 1'b1;
            end
            default: en = '0;
        endcase
    end
endmodule

// File: rtl/dac_code_stage.sv
module dac_code_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wipe,
    input  logic         open,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || wipe) q[i] <= 1'b0;
            else if (open)   q[i] <= d[i];
        end
    end
endmodule

// File: rtl/dac_latch_pair.sv
module dac_latch_pair
    import dac_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] bus_data,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              xfer_n,
    input  logic              clr_n,
    output logic [CODE_W-1:0] out_code
);
    ctrl_t     ctrl;
    stage_en_t en;
    code_t     front_q;
    code_t     back_d;

    assign ctrl = '{sel_n: sel_n, wr_n: wr_n, xfer_n: xfer_n, clr_n: clr_n};

    dac_ctrl_decode u_dec (
        .ctrl (ctrl),
        .en   (en)
    );

    dac_code_stage #(.W(CODE_W)) u_front (
        .clk  (clk),
        .rst  (rst),
        .wipe (en.wipe),
        .open (en.front_open),
        .d    (bus_data),
        .q    (front_q)
    );

    // An open front stage passes the bus straight through to the back stage.
    assign back_d = en.front_open ? bus_data : front_q;

    dac_code_stage #(.W(CODE_W)) u_back (
        .clk  (clk),
        .rst  (rst),
        .wipe (en.wipe),
        .open (en.back_open),
        .d    (back_d),
        .q    (out_code)
    );
endmodule

// File: rtl/dac_latch_pair_chk.sv
module dac_latch_pair_chk
    import dac_latch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] bus_data,
    input logic              sel_n,
    input logic              wr_n,
    input logic              xfer_n,
    input logic              clr_n,
    input logic [CODE_W-1:0] front_q,
    input logic [CODE_W-1:0] out_code
);
    // R1
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> out_code == '0);
    // R7
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (out_code == '0 && front_q == '0));
    // R4
    a_r4_strobe_high_holds: assert property (@(posedge clk) disable iff (rst)
        (clr_n && wr_n) |=> ($stable(out_code) && $stable(front_q)));
    // R5
    a_r5_unselected_holds: assert property (@(posedge clk) disable iff (rst)
        (clr_n && xfer_n && sel_n) |=> ($stable(out_code) && $stable(front_q)));
    // R3
    a_r3_flow_through: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_n && !sel_n && !xfer_n) |=> out_code == $past(bus_data));
    // R3
    a_r3_transfer_front: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_n && sel_n && !xfer_n) |=> out_code == $past(front_q));
    // R6
    a_r6_front_only: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !wr_n && !sel_n && xfer_n) |=> ($stable(out_code) && front_q == $past(bus_data)));
endmodule

bind dac_latch_pair dac_latch_pair_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_data (bus_data),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .xfer_n   (xfer_n),
    .clr_n    (clr_n),
    .front_q  (front_q),
    .out_code (out_code)
);

// File: tb/dac_latch_pair_bench.sv
module dac_latch_pair_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_data = 8'h00;
    logic       sel_n = 1'b1, wr_n = 1'b1, xfer_n = 1'b1, clr_n = 1'b1;
    logic [7:0] out_code;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_front = 8'h00;
    logic [7:0] m_back = 8'h00;

    always #10 clk = ~clk;

    dac_latch_pair u_dac_latch_pair (
        .clk(clk), .rst(rst), .bus_data(bus_data), .sel_n(sel_n),
        .wr_n(wr_n), .xfer_n(xfer_n), .clr_n(clr_n), .out_code(out_code)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (out_code !== exp) begin
            failures++;
            $display("FAIL %s out_code=%02h expected=%02h", req, out_code, exp);
        end
    endtask

    // Drive one cycle of controls, let one edge pass, and update the model.
    task automatic step(input logic [7:0] d, input logic s, input logic w,
                        input logic x, input logic c);
        logic fo, bo;
        bus_data = d; sel_n = s; wr_n = w; xfer_n = x; clr_n = c;
        @(negedge clk);
        if (!c) begin
            m_front = 8'h00; m_back = 8'h00;
        end else begin
            fo = !s && !w;
            bo = !x && !w;
            if (fo) m_front = d;
            if (bo) m_back = m_front;
        end
    endtask

    function automatic string row_tag(input logic s, input logic w,
                                      input logic x, input logic c);
        if (!c) return "R7";
        if (w) return "R4";
        if (x && s) return "R5";
        if (x) return "R6";
        return "R3";
    endfunction

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1", 8'h00);
        rst = 1'b0;

        // Exhaustive sweep of control rows, each from a preloaded state.
        for (int r = 0; r < 16; r++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pre_f, pre_b, d;
                pre_b = 8'(8'h11 * (p + 1) + r);
                pre_f = 8'(~pre_b);
                d     = 8'(8'h5A ^ (r * 8'h13) ^ (p * 8'h47));
                step(pre_b, 1'b0, 1'b0, 1'b0, 1'b1);   // load both
                step(pre_f, 1'b0, 1'b0, 1'b1, 1'b1);   // load front only
                check("R2", m_back);
                step(d, r[3], r[2], r[1], r[0]);
                check(row_tag(r[3], r[2], r[1], r[0]), m_back);
                // Expose the front stage via a transfer with select high.
                step(8'hC3, 1'b1, 1'b0, 1'b0, 1'b1);
                check(row_tag(r[3], r[2], r[1], r[0]), m_back);
            end
        end

        // R3 flow-through: output equals bus one cycle later, all codes.
        for (int v = 0; v < 256; v++) begin
            step(8'(v), 1'b0, 1'b0, 1'b0, 1'b1);
            check("R3", 8'(v));
        end

        // R8 zero override while everything is open.
        step(8'hA7, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8", 8'hA7);
        for (int k = 0; k < 3; k++) begin
            step(8'hA7, 1'b0, 1'b0, 1'b0, 1'b0);
            check("R8", 8'h00);
        end
        step(8'h3E, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8", 8'h3E);

        // R9 clear pulse while latched: stays zero until a write.
        step(8'h77, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R9", 8'h00);
        for (int k = 0; k < 3; k++) begin
            step(8'hFF, 1'b0, 1'b1, 1'b0, 1'b1);
            check("R9", 8'h00);
        end
        step(8'h42, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R9", 8'h42);

        // R10 capture at strobe rise, then hold while bus changes.
        step(8'h10, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8'h9D, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8'h01, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R10", 8'h9D);
        step(8'hE2, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R10", 8'h9D);

        // R6 value written with transfer high shows only after transfer.
        step(8'h6B, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R6", 8'h9D);
        step(8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R6", 8'h9D);
        step(8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R6", 8'h9D);
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R6", 8'h6B);

        // R1 reset mid-run.
        rst = 1'b1;
        @(negedge clk);
        check("R1", 8'h00);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule